// File: doc/BRIEF.md
# Wrapping Eight-Slot Register Stack

This block keeps eight wide data registers arranged as a circular push-down stack. A three-bit top index names the physical register that currently holds the stack top. Every other slot is reached by its logical depth below that top, and the depth wraps modulo eight. Pushing moves the top index down by one and writes there. Popping reads the top and moves the index up by one. When all eight slots are already live, a further push lands on the slot that held the deepest value, so that value is lost and the push never blocks.

Commands arrive on one valid/ready channel that carries an opcode, a logical depth and a data word. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Pop and copy-top return their value on a second valid/ready channel that holds one result. While a result is waiting and `res_ready` is low, `cmd_ready` is low and the channel takes no command, so no result is ever overwritten. The host must hold `cmd_valid` and the command fields steady until the command is accepted.

After reset, the block ignores every command until it has accepted an initialise command. Outside the command channel, the top value, any logical depth chosen by `rd_pos`, the top index, and the empty/full/underflow indications can be read at all times.

Top module: `circ_stack`

## Requirements
- R1: Reset (asynchronous, active low) sets all eight slots to zero and `top_idx` to 0. After reset `empty`=1, `full`=0, `res_valid`=0 and `underflow`=0.
- R2: An accepted INIT (opcode 5) zeroes every slot, sets `top_idx` to 0 and the live count to 0, and clears `res_valid`. Before the first INIT after reset, every other accepted opcode leaves the slots, `top_idx`, the flags and the result channel unchanged.
- R3: `rd_data` shows the slot at physical index (`top_idx` + `rd_pos`) mod 8. `top_data` shows logical depth 0.
- R4: An accepted PUSH (opcode 1) decrements `top_idx` mod 8 and writes `cmd_data` at the new depth 0. Each older value then reads from a depth one greater than before.
- R5: An accepted POP (opcode 2) on a non-empty stack returns the depth-0 value on `res_data`, with `res_valid` high on the next cycle. It then increments `top_idx` mod 8, so each remaining value reads from a depth one smaller.
- R6: An accepted PEEK (opcode 3) returns the depth-0 value and changes neither `top_idx` nor the live count. On an empty stack it returns zero.
- R7: An accepted WRITE (opcode 4) replaces the slot at logical depth `cmd_pos` with `cmd_data`. It leaves every other slot, `top_idx` and the count unchanged.
- R8: A PUSH while eight values are live overwrites the deepest value (previous depth 7). The count stays at 8 and `full` stays high.
- R9: A POP on an empty stack returns zero with `res_valid` and raises `underflow` for exactly one cycle. `top_idx` does not change.
- R10: `empty` is high exactly when the live count is 0, and `full` exactly when it is 8. The count rises on each push below 8 and falls on each non-empty pop.
- R11: `cmd_ready` is low exactly when `res_valid` is high and `res_ready` is low. While the result is waiting, `res_data` holds steady.
- R12: Accepted opcodes 0, 6 and 7 change no state and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode: 1 push, 2 pop, 3 peek, 4 write, 5 init, others no-op |
| cmd_pos | input | 3 | Logical depth for WRITE |
| cmd_data | input | 80 | Operand for PUSH and WRITE |
| res_valid | output | 1 | Result of POP/PEEK waiting |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 80 | Result value |
| rd_pos | input | 3 | Logical depth to show on rd_data |
| rd_data | output | 80 | Value at depth rd_pos |
| top_data | output | 80 | Value at depth 0 |
| top_idx | output | 3 | Physical index of the current top |
| empty | output | 1 | No live values |
| full | output | 1 | Eight live values |
| underflow | output | 1 | One-cycle pulse after a POP on an empty stack |

## Verification
The checker assumes that a command's fields hold steady from the cycle `cmd_valid` rises until the command is accepted. It also assumes that reset holds `cmd_valid` low. Under those assumptions, the checker reads a pointer step or an underflow pulse as the effect of the command accepted one edge earlier. The bench drives each command from a task that raises `cmd_valid` at a falling edge, keeps every field fixed while `cmd_ready` is low, and lowers `cmd_valid` at the falling edge after acceptance. During reset it keeps `cmd_valid` low.

// File: rtl/circ_stack_pkg.sv
package circ_stack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_PEEK  = 3'd3,
    OP_WRITE = 3'd4,
    OP_INIT  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/circ_stack_ctrl.sv
// Top index, live count and the enable decode for the slot bank.
module circ_stack_ctrl
  import circ_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [2:0]       op,
  input  logic [PTR_W-1:0] pos,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             clr_all,
  output logic             take_res,
  output logic             pop_miss,
  output logic [PTR_W-1:0] top_q,
  output logic             is_empty,
  output logic             is_full
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic             live_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop, do_peek, do_write, pop_hit;

  assign clr_all  = acc && (op == OP_INIT);
  assign do_push  = acc && live_q && (op == OP_PUSH);
  assign do_pop   = acc && live_q && (op == OP_POP);
  assign do_peek  = acc && live_q && (op == OP_PEEK);
  assign do_write = acc && live_q && (op == OP_WRITE);
  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CNT_MAX);
  assign pop_hit  = do_pop && !is_empty;
  assign pop_miss = do_pop && is_empty;
  assign take_res = do_pop || do_peek;
  assign wr_en    = do_push || do_write;
  assign wr_idx   = do_push ? top_q - 1'b1 : top_q + pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      top_q  <= '0;
      cnt_q  <= '0;
    end else if (clr_all) begin
      live_q <= 1'b1;
      top_q  <= '0;
      cnt_q  <= '0;
    end else if (do_push) begin
      top_q <= top_q - 1'b1;
      if (!is_full) cnt_q <= cnt_q + 1'b1;
    end else if (pop_hit) begin
      top_q <= top_q + 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/circ_stack_bank.sv
// Physical slot storage: one register per slot.
module circ_stack_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_all,
  input  logic                        wr_en,
  input  logic [PTR_W-1:0]            wr_idx,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] slots
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (clr_all)
        slots[g] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(g)))
        slots[g] <= wr_data;
    end
  end
endmodule

// File: rtl/circ_stack_rdmux.sv
// Logical-depth read port: physical index = base + depth, wrapping.
module circ_stack_rdmux #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] slots,
  input  logic [PTR_W-1:0]            base,
  input  logic [PTR_W-1:0]            depth,
  output logic [WIDTH-1:0]            dout
);
  logic [PTR_W-1:0] phys;
  assign phys = base + depth;
  assign dout = slots[phys];
endmodule

// File: rtl/circ_stack.sv
module circ_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [PTR_W-1:0] cmd_pos,
  input  logic [WIDTH-1:0] cmd_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_data,
  input  logic [PTR_W-1:0] rd_pos,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] top_data,
  output logic [PTR_W-1:0] top_idx,
  output logic             empty,
  output logic             full,
  output logic             underflow
);
  logic                        acc, wr_en, clr_all, take_res, pop_miss;
  logic [PTR_W-1:0]            wr_idx;
  logic [DEPTH-1:0][WIDTH-1:0] slots;

  assign cmd_ready = !res_valid || res_ready;
  assign acc       = cmd_valid && cmd_ready;

  circ_stack_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(cmd_op), .pos(cmd_pos),
    .wr_en(wr_en), .wr_idx(wr_idx), .clr_all(clr_all), .take_res(take_res),
    .pop_miss(pop_miss), .top_q(top_idx), .is_empty(empty), .is_full(full)
  );

  circ_stack_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) bank_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(cmd_data), .slots(slots)
  );

  circ_stack_rdmux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) top_rd_i (
    .slots(slots), .base(top_idx), .depth('0), .dout(top_data)
  );

  circ_stack_rdmux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) pos_rd_i (
    .slots(slots), .base(top_idx), .depth(rd_pos), .dout(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= pop_miss;
      if (clr_all) begin
        res_valid <= 1'b0;
        res_data  <= '0;
      end else if (take_res) begin
        res_valid <= 1'b1;
        res_data  <= empty ? '0 : top_data;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/circ_stack_chk.sv
module circ_stack_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [WIDTH-1:0] cmd_data,
  input logic             res_valid,
  input logic             res_ready,
  input logic [WIDTH-1:0] res_data,
  input logic [WIDTH-1:0] top_data,
  input logic [PTR_W-1:0] top_idx,
  input logic             empty,
  input logic             full,
  input logic             underflow
);
  logic seen_init;
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_init <= 1'b0;
    else if (acc && cmd_op == 3'd5) seen_init <= 1'b1;
  end

  // R2
  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd5 |=> empty && !full && top_idx == '0 && !res_valid);

  // R4
  a_r4_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen_init && cmd_op == 3'd1 |=> top_idx == $past(top_idx) - 1'b1);

  a_r4_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen_init && cmd_op == 3'd1 |=> top_data == $past(cmd_data));

  // R5
  a_r5_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen_init && cmd_op == 3'd2 && !empty |=> top_idx == $past(top_idx) + 1'b1);

  // R9
  a_r9_uflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(acc && seen_init && cmd_op == 3'd2 && empty));

  a_r9_uflow_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $stable(top_idx));

  // R10
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R11
  a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
endmodule

bind circ_stack circ_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .top_data(top_data),
  .top_idx(top_idx), .empty(empty), .full(full), .underflow(underflow)
);

// File: tb/circ_stack_tb_top.sv
`timescale 1ns/1ps
module circ_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_pos = '0;
  logic [79:0] cmd_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [79:0] res_data;
  logic [2:0]  rd_pos = '0;
  logic [79:0] rd_data, top_data;
  logic [2:0]  top_idx;
  logic        empty, full, underflow;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected state built from the requirements
  logic [79:0] m_slot [8];
  logic [2:0]  m_top;
  int          m_cnt;

  always #4 clk = ~clk;

  circ_stack dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pos(cmd_pos), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .rd_pos(rd_pos), .rd_data(rd_data), .top_data(top_data),
    .top_idx(top_idx), .empty(empty), .full(full), .underflow(underflow)
  );

  function automatic logic [79:0] val(input int k);
    return {16'hC3A5, 32'(k * 7 + 1), 32'(~k)};
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 8; i++) m_slot[i] = '0;
    m_top = '0;
    m_cnt = 0;
  endtask

  task automatic m_push(input logic [79:0] d);
    m_top = m_top - 3'd1;
    m_slot[m_top] = d;
    if (m_cnt < 8) m_cnt++;
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] pos, input logic [79:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pos = pos; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic check_state(input string req);
    chk({req, " top_idx"}, 80'(top_idx), 80'(m_top));
    chk({req, " empty"}, 80'(empty), 80'(m_cnt == 0));
    chk({req, " full"}, 80'(full), 80'(m_cnt == 8));
    chk({req, " top_data"}, top_data, m_slot[m_top]);
    for (int p = 0; p < 8; p++) begin
      rd_pos = 3'(p);
      #1;
      chk({req, " rd_data"}, rd_data, m_slot[3'(m_top + 3'(p))]);
    end
  endtask

  task automatic t_reset();
    m_reset();
    check_state("R1 reset");
    chk("R1 res_valid", 80'(res_valid), 80'(0));
    chk("R1 underflow", 80'(underflow), 80'(0));
  endtask

  task automatic t_pre_init();
    issue(3'd1, 3'd0, val(99));
    issue(3'd4, 3'd3, val(98));
    issue(3'd3, 3'd0, '0);
    check_state("R2 ignored before init");
    chk("R2 no result before init", 80'(res_valid), 80'(0));
    issue(3'd5, 3'd0, '0);
    m_reset();
    check_state("R2 after init");
  endtask

  task automatic t_push_pop();
    for (int k = 1; k <= 3; k++) begin
      issue(3'd1, 3'd0, val(k));
      m_push(val(k));
    end
    check_state("R4 R3 after pushes");
    issue(3'd2, 3'd0, '0);
    chk("R5 pop res_valid", 80'(res_valid), 80'(1));
    chk("R5 pop value", res_data, val(3));
    m_top = m_top + 3'd1; m_cnt--;
    check_state("R5 R10 after pop");
  endtask

  task automatic t_peek_write();
    issue(3'd3, 3'd0, '0);
    chk("R6 peek res_valid", 80'(res_valid), 80'(1));
    chk("R6 peek value", res_data, val(2));
    check_state("R6 peek keeps state");
    issue(3'd4, 3'd1, val(50));
    m_slot[3'(m_top + 3'd1)] = val(50);
    check_state("R7 write depth 1");
    issue(3'd6, 3'd2, val(51));
    issue(3'd0, 3'd2, val(52));
    issue(3'd7, 3'd2, val(53));
    check_state("R12 unknown ops");
    chk("R12 no result", 80'(res_valid), 80'(0));
  endtask

  task automatic t_overflow();
    for (int k = 10; k < 20; k++) begin
      issue(3'd1, 3'd0, val(k));
      m_push(val(k));
    end
    check_state("R8 wrap overwrite");
    chk("R8 bottom is oldest kept", m_slot[3'(m_top + 3'd7)], val(12));
    for (int k = 0; k < 8; k++) begin
      issue(3'd2, 3'd0, '0);
      chk("R5 drain value", res_data, m_slot[m_top]);
      m_top = m_top + 3'd1; m_cnt--;
    end
    check_state("R10 drained");
  endtask

  task automatic t_underflow();
    logic [2:0] t0;
    t0 = top_idx;
    issue(3'd2, 3'd0, '0);
    chk("R9 underflow pulse", 80'(underflow), 80'(1));
    chk("R9 zero result", res_data, '0);
    chk("R9 res_valid", 80'(res_valid), 80'(1));
    chk("R9 top unchanged", 80'(top_idx), 80'(t0));
    @(negedge clk); #1;
    chk("R9 pulse one cycle", 80'(underflow), 80'(0));
    issue(3'd3, 3'd0, '0);
    chk("R6 empty peek zero", res_data, '0);
    chk("R6 no underflow on peek", 80'(underflow), 80'(0));
  endtask

  task automatic t_backpressure();
    logic [2:0] t0;
    issue(3'd1, 3'd0, val(70));
    m_push(val(70));
    @(negedge clk);
    res_ready = 1'b0;
    issue(3'd3, 3'd0, '0);
    chk("R11 result waiting", 80'(res_valid), 80'(1));
    chk("R11 ready low", 80'(cmd_ready), 80'(0));
    t0 = top_idx;
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = val(71);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R11 stalled top", 80'(top_idx), 80'(t0));
      chk("R11 held result", res_data, val(70));
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    m_push(val(71));
    chk("R11 result consumed", 80'(res_valid), 80'(0));
    check_state("R11 push after release");
    issue(3'd5, 3'd0, '0);
    m_reset();
    check_state("R2 re-init");
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_pre_init();
    t_push_pop();
    t_peek_write();
    t_overflow();
    t_underflow();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule